// File: doc/BRIEF.md
# Peripheral Input Port Controller

This block connects a CPU-side register bus to a simple byte-wide input device. Software writes a command to start a fetch. The controller then runs a four-phase request/acknowledge exchange with the device and captures the byte the device presents. It holds that byte in a data register and raises a ready flag. Software can poll the flag through the status register, or enable an interrupt line that rises together with the flag and is taken down by a dedicated acknowledge input.

Reading the data register or writing the clear command removes the flag, and the next fetch can start only after that. A programmable watchdog limits how long the request may wait for the device. When the limit runs out, a sticky error bit is set and the controller drops the request and returns to idle. Register reads are combinational within the access cycle. Writes and read side effects take effect at the clock edge of the access.

Register map on `bus_addr`: 0 is the byte data register, read-only, with the byte in bits 7:0 and zeros above. 1 is the control/status register. 2 is the timeout limit. Address 3 reads as zero. In a write to address 1, bit 0 starts a fetch, bit 1 clears ready, bit 2 is the stored interrupt enable and bit 3 clears the error. A read of address 1 returns ready in bit 0, busy in bit 1, interrupt enable in bit 2, error in bit 3 and pending interrupt in bit 4, with zeros above.

Top module: `byte_in_port`

## Requirements
- R1: After reset, `dev_req` and `irq` are low, a status read returns 0 and the timeout register reads back its reset value (default 100).
- R2: A write to address 1 with bit 0 set, made while idle and with ready clear, raises `dev_req` in the cycle after the write edge.
- R3: The first clock edge at which `dev_ack` is high after being low, while `dev_req` is high, stores `dev_data` and sets ready (status bit 0). `dev_req` drops after that edge, and busy (status bit 1) stays set until `dev_ack` is seen low. A read of address 0 then returns the byte in bits 7:0.
- R4: A start command is ignored while a fetch is busy or while ready is set: `dev_req` does not rise and a running timeout is not restarted.
- R5: Ready is cleared by a read of address 0 or by a write to address 1 with bit 1 set. A byte captured in the same cycle keeps ready set.
- R6: With the interrupt enable (status bit 2, written through control bit 2) set, `irq` rises in the same cycle as ready. With it clear, `irq` stays low and no interrupt is left pending.
- R7: Once raised, `irq` stays high until `irq_ack` is sampled high or ready is cleared, whichever comes first. Neither event clears ready on its own, except that a ready clear clears ready.
- R8: If `dev_ack` does not rise within L clock edges of `dev_req` rising (L is the timeout register, where values 0 and 1 both mean one edge), the error bit (status bit 3) is set, `dev_req` drops and ready stays clear. The error bit holds until a write to address 1 with bit 3 set.
- R9: A write to address 2 sets the timeout limit, and a read of address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is selected |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge from the CPU |
| dev_req | output | 1 | Request to the device |
| dev_ack | input | 1 | Acknowledge from the device |
| dev_data | input | 8 | Byte from the device, sampled on the acknowledge rise |

## Verification
The fetch is run against a device that answers after a short delay, a device that answers with different byte values, and a device that never answers. The first two show that the byte comes from the acknowledge edge and that the handshake phases run in order. The silent device shows that the watchdog fires after exactly the programmed number of edges. Repeated start commands are issued during a pending fetch and with ready still set, so a controller that restarts its timer or overwrites the byte can be told apart from a correct one. Polled runs, interrupt runs ended by an acknowledge, and interrupt runs ended by a data read each separate the two ways `irq` can fall.

// File: rtl/bip_pkg.sv
package bip_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_REL  = 2'd2
  } fetch_st_t;

  localparam int unsigned REG_DATA = 0;
  localparam int unsigned REG_CTRL = 1;
  localparam int unsigned REG_TMO  = 2;

  // control write bits
  localparam int unsigned CB_START   = 0;
  localparam int unsigned CB_CLR_RDY = 1;
  localparam int unsigned CB_IEN     = 2;
  localparam int unsigned CB_CLR_ERR = 3;

  // status read bits
  localparam int unsigned SB_RDY  = 0;
  localparam int unsigned SB_BUSY = 1;
  localparam int unsigned SB_IEN  = 2;
  localparam int unsigned SB_ERR  = 3;
  localparam int unsigned SB_IRQ  = 4;
  localparam int unsigned SB_W    = 5;

  typedef struct packed {
    logic start;
    logic clr_rdy;
    logic clr_err;
  } bip_cmd_t;

endpackage

// File: rtl/bip_rst_sync.sv
module bip_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bip_regs.sv
module bip_regs
  import bip_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned TMO_INIT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rdy_i,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic              irq_i,
  input  logic [BYTE_W-1:0] byte_i,
  output bip_cmd_t          cmd_o,
  output logic              data_rd_o,
  output logic              ien_o,
  output logic [TMO_W-1:0]  tmo_lim_o
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(REG_TMO);

  logic             wr_ctrl, wr_tmo, rd_any;
  logic             ien_q, ien_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic [SB_W-1:0]  status;

  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_tmo  = bus_sel && bus_wr && (bus_addr == A_TMO);
  assign rd_any  = bus_sel && !bus_wr;

  always_comb begin
    cmd_o.start   = wr_ctrl && bus_wdata[CB_START];
    cmd_o.clr_rdy = wr_ctrl && bus_wdata[CB_CLR_RDY];
    cmd_o.clr_err = wr_ctrl && bus_wdata[CB_CLR_ERR];
    data_rd_o     = rd_any && (bus_addr == A_DATA);
  end

  always_comb begin
    ien_d = wr_ctrl ? bus_wdata[CB_IEN] : ien_q;
    tmo_d = wr_tmo  ? bus_wdata[TMO_W-1:0] : tmo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      tmo_q <= TMO_W'(TMO_INIT);
    end else begin
      ien_q <= ien_d;
      tmo_q <= tmo_d;
    end
  end

  always_comb begin
    status          = '0;
    status[SB_RDY]  = rdy_i;
    status[SB_BUSY] = busy_i;
    status[SB_IEN]  = ien_q;
    status[SB_ERR]  = err_i;
    status[SB_IRQ]  = irq_i;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        A_DATA:  bus_rdata[BYTE_W-1:0] = byte_i;
        A_CTRL:  bus_rdata[SB_W-1:0]   = status;
        A_TMO:   bus_rdata[TMO_W-1:0]  = tmo_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign ien_o     = ien_q;
  assign tmo_lim_o = tmo_q;

  AST_TMO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmo |=> (tmo_lim_o == $past(bus_wdata[TMO_W-1:0]))); // R9
endmodule

// File: rtl/bip_fetch.sv
module bip_fetch
  import bip_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              clr_rdy_i,
  input  logic              clr_err_i,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic              dev_ack_i,
  input  logic [BYTE_W-1:0] dev_data_i,
  output logic              dev_req_o,
  output logic              rdy_o,
  output logic              err_o,
  output logic              busy_o,
  output logic              rdy_set_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam logic [TMO_W-1:0] CNT_ONE = TMO_W'(1);
  localparam logic [TMO_W:0]   EXT_ONE = (TMO_W+1)'(1);

  fetch_st_t         st_q, st_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_en;
  logic              rdy_q, rdy_d, err_q, err_d, ack_q;
  logic              ack_rise, tmo_hit, set_rdy;

  assign ack_rise = dev_ack_i && !ack_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    byte_en = 1'b0;
    set_rdy = 1'b0;
    tmo_hit = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (start_i && !rdy_q) begin
          st_d  = FS_REQ;
          cnt_d = '0;
        end
      end
      FS_REQ: begin
        if (ack_rise) begin
          byte_en = 1'b1;
          set_rdy = 1'b1;
          st_d    = FS_REL;
        end else if (({1'b0, cnt_q} + EXT_ONE) >= {1'b0, tmo_lim_i}) begin
          tmo_hit = 1'b1;
          st_d    = FS_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      FS_REL: begin
        if (!dev_ack_i) st_d = FS_IDLE;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_comb begin
    rdy_d = set_rdy ? 1'b1 : (clr_rdy_i ? 1'b0 : rdy_q);
    err_d = tmo_hit ? 1'b1 : (clr_err_i ? 1'b0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
      rdy_q <= 1'b0;
      err_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
      err_q <= err_d;
      ack_q <= dev_ack_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= '0;
    else if (byte_en) byte_q <= dev_data_i;
  end

  assign dev_req_o = (st_q == FS_REQ);
  assign busy_o    = (st_q != FS_IDLE);
  assign rdy_o     = rdy_q;
  assign err_o     = err_q;
  assign rdy_set_o = set_rdy;
  assign byte_o    = byte_q;

  AST_RDY_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> ($past(dev_req_o) && $past(dev_ack_i))); // R3
  AST_TMO_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!dev_req_o && !rdy_q)); // R8
  AST_REQ_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req_o) |-> !rdy_q); // R4
endmodule

// File: rtl/bip_irq.sv
module bip_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ien_i,
  input  logic rdy_set_i,
  input  logic rdy_clr_i,
  input  logic rdy_i,
  input  logic irq_ack_i,
  output logic irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    if (rdy_set_i && ien_i)          irq_d = 1'b1;
    else if (irq_ack_i || rdy_clr_i) irq_d = 1'b0;
    else                             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> rdy_i); // R7
  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !rdy_set_i) |=> !irq_o); // R7
  AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_set_i && !ien_i && !irq_o) |=> !irq_o); // R6
endmodule

// File: rtl/byte_in_port.sv
module byte_in_port
  import bip_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned TMO_INIT = 100,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              irq_ack,
  output logic              dev_req,
  input  logic              dev_ack,
  input  logic [BYTE_W-1:0] dev_data
);
  logic              rst_i_n;
  bip_cmd_t          cmd;
  logic              data_rd, ien, rdy, err, busy, rdy_set, clr_rdy;
  logic [TMO_W-1:0]  tmo_lim;
  logic [BYTE_W-1:0] byte_val;

  assign clr_rdy = cmd.clr_rdy || data_rd;

  bip_rst_sync #(.STAGES(SYNC_STG)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  bip_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
    .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)
  ) i_regs (
    .clk(clk), .rst_n(rst_i_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rdy_i(rdy), .busy_i(busy), .err_i(err), .irq_i(irq), .byte_i(byte_val),
    .cmd_o(cmd), .data_rd_o(data_rd), .ien_o(ien), .tmo_lim_o(tmo_lim)
  );

  bip_fetch #(.BYTE_W(BYTE_W), .TMO_W(TMO_W)) i_fetch (
    .clk(clk), .rst_n(rst_i_n),
    .start_i(cmd.start), .clr_rdy_i(clr_rdy), .clr_err_i(cmd.clr_err),
    .tmo_lim_i(tmo_lim), .dev_ack_i(dev_ack), .dev_data_i(dev_data),
    .dev_req_o(dev_req), .rdy_o(rdy), .err_o(err), .busy_o(busy),
    .rdy_set_o(rdy_set), .byte_o(byte_val)
  );

  bip_irq i_irq (
    .clk(clk), .rst_n(rst_i_n),
    .ien_i(ien), .rdy_set_i(rdy_set), .rdy_clr_i(clr_rdy), .rdy_i(rdy),
    .irq_ack_i(irq_ack), .irq_o(irq)
  );
endmodule

// File: tb/test_byte_in_port.sv
module test_byte_in_port;
  localparam int CLK_P    = 10;
  localparam int TMO_INIT = 100;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq, irq_ack = 1'b0, dev_req;
  logic        dev_ack = 1'b0;
  logic [7:0]  dev_data = '0;

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_on = 0;

  // device behaviour
  bit       dev_stuck = 0;
  int       dev_delay = 3;
  logic [7:0] dev_byte = 8'h00;
  int       dcnt = 0;

  // reference model state
  int         m_rel, m_st, m_cnt, m_tmo;
  bit         m_rdy, m_err, m_ien, m_irq, m_ackq;
  logic [7:0] m_byte;

  byte_in_port i_byte_in_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_ack(irq_ack), .dev_req(dev_req), .dev_ack(dev_ack),
    .dev_data(dev_data)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // device: answers a request after dev_delay cycles unless stuck
  always @(negedge clk) begin
    if (!rst_n) begin
      dev_ack = 1'b0; dcnt = 0;
    end else if (!dev_ack) begin
      if (dev_req && !dev_stuck) begin
        if (dcnt >= dev_delay) begin
          dev_ack = 1'b1; dev_data = dev_byte; dcnt = 0;
        end else dcnt++;
      end else dcnt = 0;
    end else if (!dev_req) begin
      dev_ack = 1'b0; dev_data = 8'hxx;
    end
  end

  // behavioural reference model, updated at each clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_st = 0; m_cnt = 0; m_tmo = TMO_INIT;
      m_rdy = 0; m_err = 0; m_ien = 0; m_irq = 0; m_ackq = 0; m_byte = 8'h00;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit cw, dr, rise, srdy, hit, clr;
      cw   = bus_sel && bus_wr && bus_addr == 2'd1;
      dr   = bus_sel && !bus_wr && bus_addr == 2'd0;
      rise = dev_ack && !m_ackq;
      srdy = 0; hit = 0;
      if (m_st == 0) begin
        if (cw && bus_wdata[0] && !m_rdy) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (rise) begin m_byte = dev_data; srdy = 1; m_st = 2; end
        else if (m_cnt + 1 >= m_tmo) begin hit = 1; m_st = 0; end
        else m_cnt++;
      end else if (!dev_ack) m_st = 0;
      clr = (cw && bus_wdata[1]) || dr;
      if (srdy && m_ien) m_irq = 1; else if (irq_ack || clr) m_irq = 0;
      if (srdy) m_rdy = 1; else if (clr) m_rdy = 0;
      if (hit) m_err = 1; else if (cw && bus_wdata[3]) m_err = 0;
      if (cw) m_ien = bus_wdata[2];
      if (bus_sel && bus_wr && bus_addr == 2'd2) m_tmo = int'(bus_wdata);
      m_ackq = dev_ack;
    end
  end

  // per-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cmp_on) begin
      logic [15:0] exp_rd;
      exp_rd = '0;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          2'd0: exp_rd = {8'h00, m_byte};
          2'd1: exp_rd = {11'd0, m_irq, m_err, m_ien, (m_st != 0), m_rdy};
          2'd2: exp_rd = 16'(m_tmo);
          default: exp_rd = '0;
        endcase
      end
      chk(dev_req === (m_st == 1), "R2/R3/R8 dev_req vs model", 32'(dev_req), 32'(m_st == 1));
      chk(irq === m_irq, "R6/R7 irq vs model", 32'(irq), 32'(m_irq));
      chk(bus_rdata === exp_rd, "R5 rdata vs model", 32'(bus_rdata), 32'(exp_rd));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic bwr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    cmp_on = 1;

    // reset state
    chk(dev_req === 1'b0, "R1 dev_req after reset", 32'(dev_req), 0);
    chk(irq === 1'b0, "R1 irq after reset", 32'(irq), 0);
    brd(2'd1, v); chk(v === 16'h0000, "R1 status after reset", 32'(v), 0);
    brd(2'd2, v); chk(v === 16'(TMO_INIT), "R1 timeout reset value", 32'(v), TMO_INIT);

    // timeout register
    bwr(2'd2, 16'd50);
    brd(2'd2, v); chk(v === 16'd50, "R9 timeout readback", 32'(v), 50);

    // polled fetch
    dev_delay = 3; dev_byte = 8'hA5;
    bwr(2'd1, 16'h0001);
    chk(dev_req === 1'b1, "R2 request after start", 32'(dev_req), 1);
    idle(12);
    brd(2'd1, v); chk(v === 16'h0001, "R3 ready set, idle, no irq", 32'(v), 1);
    chk(irq === 1'b0, "R6 no irq when disabled", 32'(irq), 0);
    brd(2'd0, v); chk(v === 16'h00A5, "R3 captured byte", 32'(v), 32'h00A5);
    brd(2'd1, v); chk(v[0] === 1'b0, "R5 data read clears ready", 32'(v[0]), 0);

    // interrupt fetch ended by acknowledge
    dev_byte = 8'h3C;
    bwr(2'd1, 16'h0005);
    idle(12);
    chk(irq === 1'b1, "R6 irq with ready", 32'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(irq === 1'b0, "R7 irq dropped by ack", 32'(irq), 0);
    brd(2'd1, v); chk(v === 16'h0005, "R7 ready kept after ack", 32'(v), 5);
    brd(2'd0, v); chk(v === 16'h003C, "R3 second byte", 32'(v), 32'h003C);
    bwr(2'd1, 16'h0006);
    brd(2'd1, v); chk(v === 16'h0004, "R5 clear bit clears ready", 32'(v), 4);

    // interrupt fetch ended by data read
    dev_delay = 0; dev_byte = 8'h81;
    bwr(2'd1, 16'h0005);
    idle(8);
    chk(irq === 1'b1, "R6 irq second run", 32'(irq), 1);
    brd(2'd0, v); chk(v === 16'h0081, "R3 fast device byte", 32'(v), 32'h0081);
    chk(irq === 1'b0, "R7 irq dropped by ready clear", 32'(irq), 0);

    // start refused while ready set
    dev_byte = 8'h5A;
    bwr(2'd1, 16'h0001);
    idle(8);
    dev_byte = 8'hFF;
    bwr(2'd1, 16'h0001);
    idle(2);
    chk(dev_req === 1'b0, "R4 no request while ready", 32'(dev_req), 0);
    brd(2'd0, v); chk(v === 16'h005A, "R4 byte not overwritten", 32'(v), 32'h005A);

    // stalled device, repeated start while pending
    dev_stuck = 1;
    bwr(2'd2, 16'd20);
    bwr(2'd1, 16'h0001);
    idle(8);
    bwr(2'd1, 16'h0001);
    idle(12);
    chk(dev_req === 1'b0, "R4 timer not restarted by second start", 32'(dev_req), 0);
    brd(2'd1, v); chk(v === 16'h0008, "R8 error set, ready clear", 32'(v), 8);
    idle(3);
    brd(2'd1, v); chk(v === 16'h0008, "R8 error sticky", 32'(v), 8);
    bwr(2'd1, 16'h0008);
    brd(2'd1, v); chk(v === 16'h0000, "R8 error cleared", 32'(v), 0);

    // minimum limit: one edge
    bwr(2'd2, 16'd1);
    bwr(2'd1, 16'h0001);
    chk(dev_req === 1'b1, "R2 request with limit one", 32'(dev_req), 1);
    idle(1);
    chk(dev_req === 1'b0, "R8 one-edge timeout", 32'(dev_req), 0);
    brd(2'd1, v); chk(v === 16'h0008, "R8 error after one edge", 32'(v), 8);

    dev_stuck = 0;
    idle(4);
    cmp_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule